// File: doc/BRIEF.md
# Four-Level Linear-to-Physical Address Walker

The block turns a 64-bit linear address into a physical address by reading up to four levels of translation tables held in memory. A request is accepted on a valid/ready handshake, and the base of the top-level table comes from a register outside the block. The block issues one 64-bit entry read at a time and follows the entry pointers down the hierarchy. When it reaches a page it returns the physical address and the page size. If the address is rejected, or an entry is marked absent, it returns a fault instead.

The address is checked before any table is touched. Only 48 bits are significant, so bits 63:47 must be all zeros or all ones. An address that fails this check gets a fault reply on the next cycle, and no memory read is made. A large-page flag in a directory-pointer or directory entry ends the walk early, which gives a 1 GB or a 2 MB page. Otherwise the walk reaches the page-table level and maps a 4 KB page.

Top module: `ptWalker`

## Requirements
- R1: After reset, reqReady is 1, rspValid is 0 and memRdEn is 0.
- R2: An accepted address whose bits 63:47 are not all equal gets rspValid with rspCode 1 (non-canonical) in the cycle right after acceptance, and no memory read is issued for it.
- R3: The entry read at each level has address tableBase + 8 × index. The index is linear-address bits 47:39 at the top map (level 3), 38:30 at the directory-pointer table (level 2), 29:21 at the directory (level 1) and 20:12 at the page table (level 0). The top table base is the rootBase value sampled at acceptance.
- R4: A present, non-leaf entry gives the next table base as entry bits 51:12, followed by 12 zero bits.
- R5: An entry with bit 0 (present) clear ends the walk. The reply has rspCode 2 (not present), rspLevel is the level at which the walk stopped (3, 2, 1 or 0), and no further read is made.
- R6: A present directory-pointer entry with bit 7 set gives a 1 GB page after exactly 2 reads. The reply has rspCode 0, rspSize 2, and rspPhys = {entry[51:30], address[29:0]}.
- R7: A present directory entry with bit 7 set gives a 2 MB page after exactly 3 reads. The reply has rspCode 0, rspSize 1, and rspPhys = {entry[51:21], address[20:0]}.
- R8: A present page-table entry gives a 4 KB page after exactly 4 reads. The reply has rspSize 0 and rspPhys = {entry[51:12], address[11:0]}. Bit 7 is ignored in top-map and page-table entries, and entry bits 63:52 never reach rspPhys.
- R9: Only one read is outstanding at a time: memRdEn is high for a single cycle per level. reqReady stays low from acceptance until the reply. rspValid is a one-cycle pulse, and reqReady returns high in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rootBase | input | 52 | Physical base of the top-level table |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to accept |
| reqAddr | input | 64 | Linear address to translate |
| memRdEn | output | 1 | One-cycle entry read strobe |
| memRdAddr | output | 52 | Physical address of the entry to read |
| memRdDataValid | input | 1 | Entry data returned |
| memRdData | input | 64 | Returned table entry |
| rspValid | output | 1 | One-cycle reply strobe |
| rspCode | output | 2 | 0 ok, 1 non-canonical, 2 not present |
| rspLevel | output | 2 | Level at which the walk ended (3 top map … 0 page table) |
| rspSize | output | 2 | 0 4 KB, 1 2 MB, 2 1 GB |
| rspPhys | output | 52 | Translated physical address |

## Verification
The assertions assume that memory answers each read strobe with exactly one memRdDataValid beat, and never raises that signal without a read pending. They also assume that rootBase is stable at acceptance. The bench's memory model answers every strobe in the following cycle with a value from a sparse table, or zero for an unmapped address. Requests are raised only while reqReady is high, and the next request waits until the reply has arrived. Expected results come from an arithmetic walk over the same sparse table, sweeping index combinations that reach every page size and every fault level, and flipping each upper address bit.

// File: rtl/ptwPkg.sv
package ptwPkg;
  localparam int PRESENT_BIT = 0;
  localparam int PS_BIT      = 7;

  localparam logic [1:0] RSP_OK         = 2'd0;
  localparam logic [1:0] RSP_NONCANON   = 2'd1;
  localparam logic [1:0] RSP_NOTPRESENT = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } ptwState_e;

  typedef struct packed {
    logic capture;
    logic setNonCanon;
    logic stepDown;
    logic takeLeaf;
    logic setNotPresent;
  } ptwStrobe_t;
endpackage

// File: rtl/ptwCtrl.sv
module ptwCtrl
  import ptwPkg::*;
#(
  parameter int LEVELS    = 4,
  parameter int LARGE_TOP = 2,
  localparam int LVL_W    = $clog2(LEVELS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqNonCanon,
  input  logic             memRdDataValid,
  input  logic             entryPresent,
  input  logic             entryPs,
  output logic             reqReady,
  output logic             memRdEn,
  output logic             rspValid,
  output logic [LVL_W-1:0] level,
  output ptwStrobe_t       strobe
);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);
  localparam logic [LVL_W-1:0] BIG_LVL = LVL_W'(LARGE_TOP);

  ptwState_e state, stateNext;
  logic [LVL_W-1:0] levelNext;
  logic isLeaf;

  // A page is reached at the bottom level, or at a large-page level with the flag set
  assign isLeaf = (level == '0) || (entryPs && (level != '0) && (level <= BIG_LVL));

  always_comb begin
    stateNext = state;
    levelNext = level;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          if (reqNonCanon) begin
            strobe.setNonCanon = 1'b1;
            stateNext = ST_RESP;
          end else begin
            levelNext = TOP_LVL;
            stateNext = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT: begin
        if (memRdDataValid) begin
          if (!entryPresent) begin
            strobe.setNotPresent = 1'b1;
            stateNext = ST_RESP;
          end else if (isLeaf) begin
            strobe.takeLeaf = 1'b1;
            stateNext = ST_RESP;
          end else begin
            strobe.stepDown = 1'b1;
            levelNext = level - 1'b1;
            stateNext = ST_ISSUE;
          end
        end
      end
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      level <= '0;
    end else begin
      state <= stateNext;
      level <= levelNext;
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign memRdEn  = (state == ST_ISSUE);
  assign rspValid = (state == ST_RESP);
endmodule

// File: rtl/ptwDatapath.sv
module ptwDatapath
  import ptwPkg::*;
#(
  parameter int VA_W     = 64,
  parameter int PA_W     = 52,
  parameter int ENTRY_W  = 64,
  parameter int RECOG    = 48,
  parameter int LEVELS   = 4,
  parameter int IDX_W    = 9,
  parameter int PG_SHIFT = 12,
  localparam int LVL_W   = $clog2(LEVELS),
  localparam int ENT_SH  = $clog2(ENTRY_W / 8)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ptwStrobe_t         strobe,
  input  logic [LVL_W-1:0]   level,
  input  logic [PA_W-1:0]    rootBase,
  input  logic [VA_W-1:0]    reqAddr,
  input  logic [ENTRY_W-1:0] memRdData,
  output logic               reqNonCanon,
  output logic               entryPresent,
  output logic               entryPs,
  output logic [PA_W-1:0]    memRdAddr,
  output logic [1:0]         rspCode,
  output logic [LVL_W-1:0]   rspLevel,
  output logic [LVL_W-1:0]   rspSize,
  output logic [PA_W-1:0]    rspPhys
);
  logic [VA_W-1:0] vaReg;
  logic [PA_W-1:0] baseReg;

  // Upper bits must replicate the highest recognised bit
  logic [VA_W-RECOG:0] upperBits;
  assign upperBits   = reqAddr[VA_W-1:RECOG-1];
  assign reqNonCanon = !((&upperBits) || !(|upperBits));

  logic [IDX_W-1:0] idxLvl  [LEVELS];
  logic [PA_W-1:0]  offMask [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : gLvl
    localparam int OFFB = PG_SHIFT + g * IDX_W;
    assign idxLvl[g]  = vaReg[OFFB +: IDX_W];
    assign offMask[g] = {{(PA_W - OFFB){1'b0}}, {OFFB{1'b1}}};
  end

  logic [IDX_W-1:0] curIdx;
  logic [PA_W-1:0]  curMask;
  logic [PA_W-1:0]  entryPa;
  logic [PA_W-1:0]  nextBase;
  logic [PA_W-1:0]  leafPhys;

  assign curIdx    = idxLvl[level];
  assign curMask   = offMask[level];
  assign memRdAddr = baseReg + {{(PA_W - IDX_W - ENT_SH){1'b0}}, curIdx, {ENT_SH{1'b0}}};

  assign entryPa      = memRdData[PA_W-1:0];
  assign entryPresent = memRdData[PRESENT_BIT];
  assign entryPs      = memRdData[PS_BIT];
  assign nextBase     = {entryPa[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
  assign leafPhys     = (entryPa & ~curMask) | (vaReg[PA_W-1:0] & curMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg    <= '0;
      baseReg  <= '0;
      rspCode  <= RSP_OK;
      rspLevel <= '0;
      rspSize  <= '0;
      rspPhys  <= '0;
    end else begin
      if (strobe.capture) begin
        vaReg   <= reqAddr;
        baseReg <= rootBase;
      end
      if (strobe.stepDown) baseReg <= nextBase;
      if (strobe.setNonCanon) begin
        rspCode  <= RSP_NONCANON;
        rspLevel <= LVL_W'(LEVELS - 1);
        rspSize  <= '0;
        rspPhys  <= '0;
      end
      if (strobe.setNotPresent) begin
        rspCode  <= RSP_NOTPRESENT;
        rspLevel <= level;
        rspSize  <= '0;
        rspPhys  <= '0;
      end
      if (strobe.takeLeaf) begin
        rspCode  <= RSP_OK;
        rspLevel <= level;
        rspSize  <= level;
        rspPhys  <= leafPhys;
      end
    end
  end
endmodule

// File: rtl/ptWalker.sv
module ptWalker
  import ptwPkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PA_W      = 52,
  parameter int ENTRY_W   = 64,
  parameter int RECOG     = 48,
  parameter int LEVELS    = 4,
  parameter int IDX_W     = 9,
  parameter int PG_SHIFT  = 12,
  parameter int LARGE_TOP = 2,
  localparam int LVL_W    = $clog2(LEVELS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PA_W-1:0]    rootBase,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [VA_W-1:0]    reqAddr,
  output logic               memRdEn,
  output logic [PA_W-1:0]    memRdAddr,
  input  logic               memRdDataValid,
  input  logic [ENTRY_W-1:0] memRdData,
  output logic               rspValid,
  output logic [1:0]         rspCode,
  output logic [LVL_W-1:0]   rspLevel,
  output logic [LVL_W-1:0]   rspSize,
  output logic [PA_W-1:0]    rspPhys
);
  ptwStrobe_t       strobe;
  logic [LVL_W-1:0] level;
  logic             reqNonCanon;
  logic             entryPresent;
  logic             entryPs;

  ptwCtrl #(
    .LEVELS   (LEVELS),
    .LARGE_TOP(LARGE_TOP)
  ) uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .reqNonCanon   (reqNonCanon),
    .memRdDataValid(memRdDataValid),
    .entryPresent  (entryPresent),
    .entryPs       (entryPs),
    .reqReady      (reqReady),
    .memRdEn       (memRdEn),
    .rspValid      (rspValid),
    .level         (level),
    .strobe        (strobe)
  );

  ptwDatapath #(
    .VA_W    (VA_W),
    .PA_W    (PA_W),
    .ENTRY_W (ENTRY_W),
    .RECOG   (RECOG),
    .LEVELS  (LEVELS),
    .IDX_W   (IDX_W),
    .PG_SHIFT(PG_SHIFT)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .level       (level),
    .rootBase    (rootBase),
    .reqAddr     (reqAddr),
    .memRdData   (memRdData),
    .reqNonCanon (reqNonCanon),
    .entryPresent(entryPresent),
    .entryPs     (entryPs),
    .memRdAddr   (memRdAddr),
    .rspCode     (rspCode),
    .rspLevel    (rspLevel),
    .rspSize     (rspSize),
    .rspPhys     (rspPhys)
  );
endmodule

// File: rtl/ptwChecker.sv
module ptwChecker #(
  parameter int VA_W     = 64,
  parameter int PA_W     = 52,
  parameter int RECOG    = 48,
  parameter int IDX_W    = 9,
  parameter int PG_SHIFT = 12,
  parameter int LVL_W    = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [VA_W-1:0]  reqAddr,
  input logic             memRdEn,
  input logic [PA_W-1:0]  memRdAddr,
  input logic             rspValid,
  input logic [1:0]       rspCode,
  input logic [LVL_W-1:0] rspSize,
  input logic [PA_W-1:0]  rspPhys
);
  localparam int OFF4K = PG_SHIFT;
  localparam int OFF2M = PG_SHIFT + IDX_W;
  localparam int OFF1G = PG_SHIFT + 2 * IDX_W;

  logic [VA_W-1:0] vaHeld;
  logic            accept;
  logic            badAddr;

  assign accept  = reqValid && reqReady;
  assign badAddr = (reqAddr[VA_W-1:RECOG-1] != '0) && (reqAddr[VA_W-1:RECOG-1] != '1);

  always_ff @(posedge clk) begin
    if (!rstN) vaHeld <= '0;
    else if (accept) vaHeld <= reqAddr;
  end

  a_r2_noncanon_reply: assert property (@(posedge clk) disable iff (!rstN)
    accept && badAddr |=> rspValid && (rspCode == 2'd1) && !memRdEn);

  a_r3_entry_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (memRdAddr[2:0] == 3'b000));

  a_r9_single_read: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> !reqReady);

  a_r9_reply_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid && reqReady);

  a_r6_offset_1g: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && (rspCode == 2'd0) && (rspSize == 2'd2) |->
      (rspPhys[OFF1G-1:0] == vaHeld[OFF1G-1:0]));

  a_r7_offset_2m: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && (rspCode == 2'd0) && (rspSize == 2'd1) |->
      (rspPhys[OFF2M-1:0] == vaHeld[OFF2M-1:0]));

  a_r8_offset_4k: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && (rspCode == 2'd0) && (rspSize == 2'd0) |->
      (rspPhys[OFF4K-1:0] == vaHeld[OFF4K-1:0]));
endmodule

bind ptWalker ptwChecker #(
  .VA_W    (VA_W),
  .PA_W    (PA_W),
  .RECOG   (RECOG),
  .IDX_W   (IDX_W),
  .PG_SHIFT(PG_SHIFT),
  .LVL_W   (LVL_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqAddr  (reqAddr),
  .memRdEn  (memRdEn),
  .memRdAddr(memRdAddr),
  .rspValid (rspValid),
  .rspCode  (rspCode),
  .rspSize  (rspSize),
  .rspPhys  (rspPhys)
);

// File: tb/sim_ptWalker.sv
`timescale 1ns/1ps
module sim_ptWalker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [51:0] rootBase = 52'h1000;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqAddr = '0;
  logic        memRdEn;
  logic [51:0] memRdAddr;
  logic        memRdDataValid = 1'b0;
  logic [63:0] memRdData = '0;
  logic        rspValid;
  logic [1:0]  rspCode;
  logic [1:0]  rspLevel;
  logic [1:0]  rspSize;
  logic [51:0] rspPhys;

  int testsRun = 0;
  int testsFailed = 0;
  int readTotal = 0;
  bit finished = 1'b0;

  logic [63:0] tbl [logic [51:0]];

  always #2.5 clk = ~clk;

  ptWalker u0 (
    .clk(clk), .rstN(rstN), .rootBase(rootBase),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdDataValid(memRdDataValid), .memRdData(memRdData),
    .rspValid(rspValid), .rspCode(rspCode), .rspLevel(rspLevel),
    .rspSize(rspSize), .rspPhys(rspPhys)
  );

  function automatic logic [63:0] readMem(input logic [51:0] a);
    return tbl.exists(a) ? tbl[a] : 64'd0;
  endfunction

  // Memory: one reply, one cycle after each read strobe
  always @(posedge clk) begin
    memRdDataValid <= memRdEn;
    memRdData      <= memRdEn ? readMem(memRdAddr) : 64'd0;
    if (memRdEn) readTotal <= readTotal + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Arithmetic walk computed from the requirements
  task automatic refWalk(input logic [63:0] va, input logic [51:0] root,
                         output logic [1:0] code, output logic [1:0] size,
                         output logic [1:0] lvlOut, output logic [51:0] phys,
                         output int reads);
    logic [51:0] base;
    code = 2'd0; size = 2'd0; lvlOut = 2'd3; phys = '0; reads = 0;
    if (va[63:47] != '0 && va[63:47] != '1) begin
      code = 2'd1;
      return;
    end
    base = root;
    for (int lv = 3; lv >= 0; lv--) begin
      logic [63:0] e;
      logic [51:0] mask;
      int offBits;
      e = readMem(base + 52'((va >> (12 + 9 * lv)) & 64'h1FF) * 52'd8);
      reads++;
      if (!e[0]) begin
        code = 2'd2; lvlOut = 2'(lv);
        return;
      end
      if (lv == 0 || ((lv == 1 || lv == 2) && e[7])) begin
        offBits = 12 + 9 * lv;
        mask = 52'((64'd1 << offBits) - 64'd1);
        phys = (e[51:0] & ~mask) | (va[51:0] & mask);
        size = 2'(lv); lvlOut = 2'(lv);
        return;
      end
      base = {e[51:12], 12'h000};
    end
  endtask

  task automatic doReq(input logic [63:0] va);
    logic [1:0] eCode, eSize, eLvl;
    logic [51:0] ePhys;
    int eReads, startReads, lat;
    refWalk(va, rootBase, eCode, eSize, eLvl, ePhys, eReads);
    @(negedge clk);
    check(reqReady == 1'b1, "R9", "ready before request", 64'(reqReady), 64'd1);
    reqValid = 1'b1;
    reqAddr = va;
    startReads = readTotal;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!rspValid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check(rspValid == 1'b1, "R9", "reply arrives", 64'(rspValid), 64'd1);
    check(rspCode == eCode, "R2/R5/R8", "code", 64'(rspCode), 64'(eCode));
    check(readTotal - startReads == eReads, "R6/R7/R8", "read count",
          64'(readTotal - startReads), 64'(eReads));
    if (eCode == 2'd1)
      check(lat == 1, "R2", "non-canonical latency", 64'(lat), 64'd1);
    if (eCode == 2'd2)
      check(rspLevel == eLvl, "R5", "fault level", 64'(rspLevel), 64'(eLvl));
    if (eCode == 2'd0) begin
      check(rspSize == eSize, "R6/R7/R8", "size", 64'(rspSize), 64'(eSize));
      check(rspPhys == ePhys, "R3/R4", "physical address", 64'(rspPhys), 64'(ePhys));
    end
    @(negedge clk);
    check(!rspValid && reqReady, "R9", "pulse then ready",
          64'({rspValid, reqReady}), 64'b01);
  endtask

  function automatic logic [63:0] mkVa(input int l4, input int l3, input int l2,
                                       input int l1, input int off);
    logic [47:0] v;
    v = {9'(l4), 9'(l3), 9'(l2), 9'(l1), 12'(off)};
    return {{16{v[47]}}, v};
  endfunction

  initial begin
    int i4 [3] = '{0, 1, 511};
    int i3 [4] = '{0, 1, 2, 511};
    int i2 [3] = '{0, 1, 2};
    int i1 [3] = '{0, 3, 5};
    int offs [2] = '{12'h000, 12'hA5F};
    logic [63:0] goodHigh;

    // Tables: top 0x1000, pointer 0x2000/0x3000, directory 0x4000, page table 0x5000
    tbl[52'h1000 + 0 * 8]   = 64'h2000 | 64'h81;               // R8 bit 7 ignored at top
    tbl[52'h1000 + 511 * 8] = 64'h3000 | 64'h1;
    tbl[52'h2000 + 0 * 8]   = 64'h4000 | 64'h1;
    tbl[52'h2000 + 1 * 8]   = 64'h4000_0000 | 64'h81;          // R6 1 GB
    tbl[52'h3000 + 0 * 8]   = 64'h4000 | 64'h1;
    tbl[52'h3000 + 511 * 8] = 64'h1_C000_0000 | 64'h81;        // R6 1 GB
    tbl[52'h4000 + 0 * 8]   = 64'h5000 | 64'h1;
    tbl[52'h4000 + 1 * 8]   = 64'h60_0000 | 64'h81;            // R7 2 MB
    tbl[52'h5000 + 0 * 8]   = 64'h8000_0000_0007_0001;         // R8 high bits dropped
    tbl[52'h5000 + 5 * 8]   = 64'hABC_D000 | 64'h81;           // R8 bit 7 ignored at leaf

    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R1", "reset ready", 64'(reqReady), 64'd1);
    check(rspValid == 1'b0, "R1", "reset reply", 64'(rspValid), 64'd0);
    check(memRdEn == 1'b0, "R1", "reset read", 64'(memRdEn), 64'd0);
    rstN = 1'b1;

    // Sweep index combinations: all page sizes and fault levels (R3..R8)
    foreach (i4[a]) foreach (i3[b]) foreach (i2[c]) foreach (i1[d]) foreach (offs[o])
      doReq(mkVa(i4[a], i3[b], i2[c], i1[d], offs[o]));

    // Canonical boundaries and single upper-bit flips (R2)
    doReq(64'h0000_7FFF_FFFF_FFFF);
    doReq(64'hFFFF_8000_0000_0000);
    doReq(64'h0000_8000_0000_0000);
    doReq(64'hFFFF_7FFF_FFFF_FFFF);
    goodHigh = mkVa(511, 511, 3, 7, 12'h123);
    for (int b = 48; b < 64; b++) begin
      doReq(64'h0 ^ (64'd1 << b));
      doReq(goodHigh ^ (64'd1 << b));
    end

    // Different root: empty table faults at the top level (R3, R5)
    rootBase = 52'h9000;
    doReq(mkVa(0, 0, 0, 0, 0));
    doReq(mkVa(511, 511, 0, 0, 0));
    rootBase = 52'h1000;
    doReq(mkVa(0, 1, 0, 0, 12'h777));

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule